// File: doc/BRIEF.md
# Priority-Reserved Write Credit Allocator

This block hands out write credits from a shared pool to requests of three urgency classes: normal, high and critical. Each class may draw on the pool only while enough credits stay free to cover the reservations kept for the classes above it. Two programmable reservation levels set the admission rule for the class of each request. The lower level protects critical traffic. The upper level protects high and critical traffic together. A credit goes back to the pool when the downstream consumer pulses the release input.

A request is answered combinationally in the cycle it is presented. The pool count moves on the following clock edge. The reservation levels are loaded through a single configuration write port. A write that breaks the ordering rules is refused, and a sticky error flag records it. The block also derives an isochronous-entry threshold from the critical level, for use by the write queue that follows it.

Top module: `wr_credit_alloc`

## Requirements
- R1: After reset the free count equals the pool size POOL (32 by default), the upper level (HIGH) is 4, the lower level (CRIT) is 3, and both error flags are 0.
- R2: `req_prio` is coded 0 = normal, 1 = high, 2 or 3 = critical. A normal request is granted in the same cycle exactly when the free count is greater than HIGH.
- R3: A high request is granted in the same cycle exactly when the free count is greater than CRIT.
- R4: A critical request is granted in the same cycle exactly when the free count is non-zero. No grant is given without `req_valid`.
- R5: On the next edge a grant lowers the free count by one and a release raises it by one. A grant and a release in the same cycle leave the count unchanged.
- R6: A release with no grant while the free count already equals POOL leaves the count unchanged. It sets `overflow_error`, which then stays set until reset.
- R7: A configuration write takes HIGH from bits 12:8 and CRIT from bits 4:0 of `cfg_wdata`. The write is accepted when HIGH ≥ CRIT, HIGH ≤ 30, and both are below POOL. Accepted values appear on the outputs and govern admission from the cycle after the write.
- R8: A write that breaks any rule of R7 leaves both levels unchanged. It sets `config_error`, which then stays set until reset.
- R9: `iso_entry_thr` always equals 31 minus the current CRIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_prio | input | 2 | Request class (0 normal, 1 high, 2/3 critical) |
| req_grant | output | 1 | Request admitted this cycle |
| crd_release | input | 1 | One credit returned this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (HIGH at 12:8, CRIT at 4:0) |
| high_thr | output | 5 | Current HIGH reservation level |
| crit_thr | output | 5 | Current CRIT reservation level |
| iso_entry_thr | output | 5 | 31 minus CRIT |
| free_count | output | 6 | Credits currently free |
| config_error | output | 1 | Sticky: an illegal configuration write was refused |
| overflow_error | output | 1 | Sticky: a release arrived with the pool full |

## Verification
`req_grant` depends on the inputs through logic only. The bench therefore samples it a short settle time after it drives a request, still in the same cycle and before the rising edge. The free count, the two levels, the derived threshold and the error flags are registered, so each is due one edge after the stimulus that moves it. The bench drives on the falling edge and checks those outputs on the next falling edge, against a model that it advances once for each edge. This model-per-edge scheme also covers the case where a level written in one cycle governs the grant of a request in the very next cycle.

// File: rtl/wr_credit_pkg.sv
package wr_credit_pkg;

    typedef enum logic [1:0] {
        PRIO_NORMAL = 2'd0,
        PRIO_HIGH   = 2'd1,
        PRIO_CRIT   = 2'd2,
        PRIO_CRIT_X = 2'd3
    } prio_e;

    // field positions in the configuration word
    localparam int HI_FIELD_LSB = 8;
    localparam int CR_FIELD_LSB = 0;
    localparam int CFG_WORD_W   = 32;

endpackage

// File: rtl/wr_credit_thr_cfg.sv
module wr_credit_thr_cfg #(
    parameter int POOL     = 32,
    parameter int THR_W    = 5,
    parameter int HIGH_MAX = 30,
    parameter int HIGH_RST = 4,
    parameter int CRIT_RST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [THR_W-1:0] wr_high,
    input  logic [THR_W-1:0] wr_crit,
    output logic [THR_W-1:0] high_q,
    output logic [THR_W-1:0] crit_q,
    output logic             err_q
);

    typedef struct packed {
        logic [THR_W-1:0] high;
        logic [THR_W-1:0] crit;
        logic             err;
    } cfg_t;

    cfg_t cur_q, nxt_d;
    logic legal;

    always_comb begin
        legal = (wr_high >= wr_crit)
             && (int'(wr_high) <= HIGH_MAX)
             && (int'(wr_high) < POOL)
             && (int'(wr_crit) < POOL);
        nxt_d = cur_q;
        if (wr_en) begin
            if (legal) begin
                nxt_d.high = wr_high;
                nxt_d.crit = wr_crit;
            end else begin
                nxt_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.high <= THR_W'(HIGH_RST);
            cur_q.crit <= THR_W'(CRIT_RST);
            cur_q.err  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign high_q = cur_q.high;
    assign crit_q = cur_q.crit;
    assign err_q  = cur_q.err;

    // R7
    thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_q >= crit_q);

    // R8
    reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !legal |=> $stable(high_q) && $stable(crit_q));

    // R8
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/wr_credit_admit.sv
module wr_credit_admit
    import wr_credit_pkg::*;
#(
    parameter int THR_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             req_valid,
    input  logic [1:0]       req_prio,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [THR_W-1:0] high_thr,
    input  logic [THR_W-1:0] crit_thr,
    output logic             grant
);

    logic [CNT_W-1:0] floor_lvl;
    logic             above;

    always_comb begin
        unique case (prio_e'(req_prio))
            PRIO_NORMAL: floor_lvl = CNT_W'(high_thr);
            PRIO_HIGH:   floor_lvl = CNT_W'(crit_thr);
            default:     floor_lvl = '0;
        endcase
        above = free_cnt > floor_lvl;
        grant = req_valid && above;
    end

endmodule

// File: rtl/wr_credit_counter.sv
module wr_credit_counter #(
    parameter int POOL  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] free_q,
    output logic             ovf_q
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(POOL);

    typedef struct packed {
        logic [CNT_W-1:0] free;
        logic             ovf;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (take && !give) begin
            nxt_d.free = cur_q.free - 1'b1;
        end else if (give && !take) begin
            if (cur_q.free == FULL) nxt_d.ovf = 1'b1;
            else                    nxt_d.free = cur_q.free + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.free <= FULL;
            cur_q.ovf  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign free_q = cur_q.free;
    assign ovf_q  = cur_q.ovf;

    // R5
    free_le_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= FULL);

    // R5
    take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !give |=> free_q == $past(free_q) - 1'b1);

    // R5
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && give |=> $stable(free_q));

    // R4
    no_empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> free_q != '0);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/wr_credit_alloc.sv
module wr_credit_alloc
    import wr_credit_pkg::*;
#(
    parameter int POOL     = 32,
    parameter int THR_W    = 5,
    parameter int HIGH_MAX = 30,
    parameter int HIGH_RST = 4,
    parameter int CRIT_RST = 3,
    parameter int CNT_W    = $clog2(POOL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_prio,
    output logic                  req_grant,
    input  logic                  crd_release,
    input  logic                  cfg_we,
    input  logic [CFG_WORD_W-1:0] cfg_wdata,
    output logic [THR_W-1:0]      high_thr,
    output logic [THR_W-1:0]      crit_thr,
    output logic [THR_W-1:0]      iso_entry_thr,
    output logic [CNT_W-1:0]      free_count,
    output logic                  config_error,
    output logic                  overflow_error
);

    localparam logic [THR_W-1:0] THR_ALL = '1;

    logic [THR_W-1:0] wr_high, wr_crit;
    logic             unused_cfg;

    assign wr_high    = cfg_wdata[HI_FIELD_LSB +: THR_W];
    assign wr_crit    = cfg_wdata[CR_FIELD_LSB +: THR_W];
    assign unused_cfg = ^cfg_wdata;

    wr_credit_thr_cfg #(
        .POOL(POOL), .THR_W(THR_W), .HIGH_MAX(HIGH_MAX),
        .HIGH_RST(HIGH_RST), .CRIT_RST(CRIT_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
        .wr_high(wr_high), .wr_crit(wr_crit),
        .high_q(high_thr), .crit_q(crit_thr), .err_q(config_error)
    );

    wr_credit_admit #(.THR_W(THR_W), .CNT_W(CNT_W)) u_admit (
        .req_valid(req_valid), .req_prio(req_prio), .free_cnt(free_count),
        .high_thr(high_thr), .crit_thr(crit_thr), .grant(req_grant)
    );

    wr_credit_counter #(.POOL(POOL), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take(req_grant), .give(crd_release),
        .free_q(free_count), .ovf_q(overflow_error)
    );

    assign iso_entry_thr = THR_ALL - crit_thr;

    // R2
    normal_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant && req_prio == 2'd0 |-> free_count > CNT_W'(high_thr));

    // R3
    high_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant && req_prio == 2'd1 |-> free_count > CNT_W'(crit_thr));

endmodule

// File: tb/wr_credit_alloc_test.sv
`timescale 1ns/1ps
module wr_credit_alloc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_prio = 2'd0;
    logic        crd_release = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_grant;
    logic [4:0]  high_thr, crit_thr, iso_entry_thr;
    logic [5:0]  free_count;
    logic        config_error, overflow_error;

    int total = 0;
    int bad = 0;
    int m_free, m_hi, m_cr, m_cerr, m_oerr;
    logic [31:0] lfsr = 32'h1D87_2B41;

    always #10 clk = ~clk;

    wr_credit_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .req_grant(req_grant), .crd_release(crd_release), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .high_thr(high_thr), .crit_thr(crit_thr),
        .iso_entry_thr(iso_entry_thr), .free_count(free_count),
        .config_error(config_error), .overflow_error(overflow_error)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state();
        chk(int'(free_count) == m_free, "R5 free count", int'(free_count), m_free);
        chk(int'(high_thr) == m_hi, "R7 high level", int'(high_thr), m_hi);
        chk(int'(crit_thr) == m_cr, "R7 crit level", int'(crit_thr), m_cr);
        chk(int'(iso_entry_thr) == 31 - m_cr, "R9 iso threshold", int'(iso_entry_thr), 31 - m_cr);
        chk(int'(config_error) == m_cerr, "R8 config error", int'(config_error), m_cerr);
        chk(int'(overflow_error) == m_oerr, "R6 overflow error", int'(overflow_error), m_oerr);
    endtask

    task automatic step(input logic v, input logic [1:0] p, input logic rel,
                        input logic we, input logic [31:0] wd);
        int eg;
        int nh;
        int nc;
        @(negedge clk);
        check_state();
        req_valid = v; req_prio = p; crd_release = rel; cfg_we = we; cfg_wdata = wd;
        #1;
        if (!v)          eg = 0;
        else if (p == 0) eg = (m_free > m_hi) ? 1 : 0;
        else if (p == 1) eg = (m_free > m_cr) ? 1 : 0;
        else             eg = (m_free > 0) ? 1 : 0;
        if (!v)          chk(int'(req_grant) == eg, "R4 idle grant", int'(req_grant), eg);
        else if (p == 0) chk(int'(req_grant) == eg, "R2 normal grant", int'(req_grant), eg);
        else if (p == 1) chk(int'(req_grant) == eg, "R3 high grant", int'(req_grant), eg);
        else             chk(int'(req_grant) == eg, "R4 critical grant", int'(req_grant), eg);
        if (eg == 1 && !rel) m_free--;
        else if (rel && eg == 0) begin
            if (m_free == 32) m_oerr = 1;
            else              m_free++;
        end
        if (we) begin
            nh = int'(wd[12:8]);
            nc = int'(wd[4:0]);
            if (nh >= nc && nh <= 30) begin m_hi = nh; m_cr = nc; end
            else m_cerr = 1;
        end
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 1'b0, 1'b0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_free = 32; m_hi = 4; m_cr = 3; m_cerr = 0; m_oerr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk(free_count == 6'd32, "R1 reset free", int'(free_count), 32);
        chk(high_thr == 5'd4, "R1 reset high", int'(high_thr), 4);
        chk(crit_thr == 5'd3, "R1 reset crit", int'(crit_thr), 3);
        chk(!config_error && !overflow_error, "R1 reset flags",
            int'(config_error) + int'(overflow_error), 0);
        rst_n = 1'b1;

        // R2 drain with normal requests: 28 grants then refusals
        for (int i = 0; i < 31; i++) step(1'b1, 2'd0, 1'b0, 1'b0, 32'd0);
        // R3 high requests take one more
        for (int i = 0; i < 3; i++) step(1'b1, 2'd1, 1'b0, 1'b0, 32'd0);
        // R4 critical codes 2 and 3 drain to zero
        for (int i = 0; i < 2; i++) step(1'b1, 2'd2, 1'b0, 1'b0, 32'd0);
        for (int i = 0; i < 3; i++) step(1'b1, 2'd3, 1'b0, 1'b0, 32'd0);
        // R5 grant and release together at empty, then refill
        step(1'b1, 2'd2, 1'b1, 1'b0, 32'd0);
        for (int i = 0; i < 34; i++) step(1'b0, 2'd0, 1'b1, 1'b0, 32'd0);
        // R6 release at full with a simultaneous grant
        step(1'b1, 2'd0, 1'b1, 1'b0, 32'd0);
        idle();

        // R7 write then use the new level on the next cycle
        step(1'b0, 2'd0, 1'b0, 1'b1, {19'd0, 5'd30, 3'd0, 5'd30});
        step(1'b1, 2'd1, 1'b0, 1'b0, 32'd0);
        step(1'b1, 2'd0, 1'b0, 1'b0, 32'd0);

        // R7 R8 exhaustive sweep of both fields, upper bits toggled
        for (int h = 0; h < 32; h++) begin
            for (int c = 0; c < 32; c++) begin
                step(1'b1, 2'(h + c), 1'b0, 1'b1,
                     {19'(h * 977 + c), 5'(h), 3'(c), 5'(c)});
            end
        end

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[0] | lfsr[1], lfsr[3:2], lfsr[4] & (lfsr[5] | lfsr[6]),
                 lfsr[10:7] == 4'd0, {lfsr[31:16], 3'd0, lfsr[15:11], 3'd0, lfsr[20:16]});
        end
        idle();
        @(negedge clk);
        check_state();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule